// File: doc/BRIEF.md
# Clock Ratio Calibration Timer

The block finds how many main-clock cycles make up one byte period of a recovered transmitter clock. It then turns protocol timeouts, written in transmitter unit intervals, into main-clock cycle counts. The host starts a measurement with a single-cycle start pulse. A toggle that flips on every transmitter byte-clock edge is brought into the main domain through a two-flop synchronizer. The block counts the main cycles that span 256 consecutive edge intervals. That count is the ratio of main cycles per byte clock, with 8 fractional bits. It is written to the ratio register only when the measurement completes, and the done flag is raised at the same moment. Both clocks are taken to be steady, so the host only requests a new measurement when it knows the rates have changed.

A client asks for an interval by giving a unit-interval count, an absolute cycle count and a mode. The block loads a down-counter and later emits a single-cycle expiry pulse. One byte clock holds 8 unit intervals, so N unit intervals become ceil(N × ratio / 2048) main cycles. A combined request adds the absolute count to that converted value and saturates the sum at the counter's full scale.

If the transmitter clock stops during a measurement, the block does not wait for ever. A watchdog on the gap between edges ends the measurement and raises a clock-missing flag.

Top module: `clk_ratio_timer`

## Requirements
- R1: After reset, `ratio` is 0 and `cal_done`, `clk_missing`, `expire` and `busy` are all 0.
- R2: A `cal_start` pulse clears `cal_done` and `clk_missing` on the next cycle. `cal_done` rises once 256 synchronized toggle edges have followed the first edge seen after the start.
- R3: On completion, `ratio` equals the number of main-clock cycles between the first counted synchronized edge and the 256th edge after it.
- R4: `ratio` keeps its previous value while a measurement is in progress and after an aborted measurement. It changes only when a measurement completes.
- R5: If no synchronized edge arrives for TMO_CYC consecutive main cycles while measuring, the measurement ends with `clk_missing`=1 and `cal_done`=0.
- R6: With `req_mode`=0 (unit intervals), the interval is T = ceil(`req_ui` × `ratio` / 2048) cycles, saturated at 2^CNT_W−1.
- R7: With `req_mode`=1 (absolute), the interval is T = `req_abs` cycles.
- R8: With `req_mode`=2 or 3 (combined), T is the converted unit-interval count plus `req_abs`, saturated at 2^CNT_W−1.
- R9: A request accepted at clock edge k produces `expire` high for exactly one cycle, following edge k+max(T,1). `busy` is high from the edge after acceptance until that pulse.
- R10: A request made while `busy` is high is ignored and produces no expiry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_tgl | input | 1 | Toggles once per transmitter byte-clock edge (asynchronous) |
| cal_start | input | 1 | Single-cycle pulse that starts a measurement |
| ratio | output | RATIO_W | Measured main cycles per byte clock, 8 fractional bits |
| cal_done | output | 1 | Measurement completed |
| clk_missing | output | 1 | Measurement aborted because edges stopped arriving |
| req_valid | input | 1 | Interval request strobe |
| req_mode | input | 2 | 0 unit intervals, 1 absolute, 2 or 3 combined |
| req_ui | input | UI_W | Interval length in unit intervals |
| req_abs | input | ABS_W | Interval length in main cycles |
| busy | output | 1 | An interval is running |
| expire | output | 1 | One-cycle pulse at the end of the interval |

## Verification
The assertions assume that `cal_start` is a one-cycle pulse and that `tx_tgl` changes no more often than once every few main cycles, so every edge reaches the synchronizer. The bench drives the toggle at least three cycles apart, from falling clock edges, with fixed or alternating periods whose 256-interval sums are known exactly. It issues interval requests only from the falling edge. It sends requests during `busy` on purpose, to check that they are dropped rather than queued.

// File: rtl/clk_ratio_timer.sv
module clk_ratio_timer #(
  parameter int RATIO_W = 20,
  parameter int UI_W    = 16,
  parameter int ABS_W   = 16,
  parameter int CNT_W   = 24,
  parameter int EDGES   = 256,
  parameter int TMO_CYC = 65535
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_tgl,
  input  logic               cal_start,
  output logic [RATIO_W-1:0] ratio,
  output logic               cal_done,
  output logic               clk_missing,
  input  logic               req_valid,
  input  logic [1:0]         req_mode,
  input  logic [UI_W-1:0]    req_ui,
  input  logic [ABS_W-1:0]   req_abs,
  output logic               busy,
  output logic               expire
);
  localparam int ECNT_W = $clog2(EDGES);
  localparam int GAP_W  = $clog2(TMO_CYC + 1);
  localparam int SHIFT  = ECNT_W + 3;
  localparam int PROD_W = UI_W + RATIO_W;
  localparam logic [PROD_W:0]  RND     = (PROD_W+1)'((1 << SHIFT) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {IDLE, ARM, MEAS} cal_st_t;

  logic [2:0]         sync_q;
  logic               tx_edge;
  cal_st_t            st;
  logic [RATIO_W-1:0] cyc, ratio_q;
  logic [ECNT_W-1:0]  ecnt;
  logic [GAP_W-1:0]   gap;
  logic               gap_out;

  assign tx_edge = sync_q[2] ^ sync_q[1];
  assign gap_out = (gap == GAP_W'(TMO_CYC - 1));
  assign ratio   = ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tx_tgl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cyc <= '0; ratio_q <= '0; ecnt <= '0; gap <= '0;
      cal_done <= 1'b0; clk_missing <= 1'b0;
    end else begin
      case (st)
        ARM: begin
          if (tx_edge) begin
            st <= MEAS; cyc <= '0; ecnt <= '0; gap <= '0;
          end else if (gap_out) begin
            st <= IDLE; clk_missing <= 1'b1;
          end else gap <= gap + 1'b1;
        end
        MEAS: begin
          cyc <= cyc + 1'b1;
          if (tx_edge) begin
            gap  <= '0;
            ecnt <= ecnt + 1'b1;
            if (ecnt == ECNT_W'(EDGES - 1)) begin
              ratio_q  <= cyc + 1'b1;
              cal_done <= 1'b1;
              st       <= IDLE;
            end
          end else if (gap_out) begin
            st <= IDLE; clk_missing <= 1'b1;
          end else gap <= gap + 1'b1;
        end
        default: ;
      endcase
      if (cal_start) begin
        st <= ARM; gap <= '0; cal_done <= 1'b0; clk_missing <= 1'b0;
      end
    end
  end

  logic [PROD_W-1:0] ui_prod;
  logic [PROD_W:0]   ui_round, ui_cyc;
  logic [CNT_W-1:0]  ui_sat, abs_ext, sum_sat, target;
  logic [CNT_W:0]    sum_full;
  logic [CNT_W-1:0]  tcnt;

  assign ui_prod  = PROD_W'(req_ui) * PROD_W'(ratio_q);
  assign ui_round = {1'b0, ui_prod} + RND;
  assign ui_cyc   = ui_round >> SHIFT;
  assign ui_sat   = (ui_cyc > {{(PROD_W+1-CNT_W){1'b0}}, CNT_MAX}) ? CNT_MAX : ui_cyc[CNT_W-1:0];
  assign abs_ext  = CNT_W'(req_abs);
  assign sum_full = {1'b0, ui_sat} + {1'b0, abs_ext};
  assign sum_sat  = sum_full[CNT_W] ? CNT_MAX : sum_full[CNT_W-1:0];

  always_comb begin
    case (req_mode)
      2'd0:    target = ui_sat;
      2'd1:    target = abs_ext;
      default: target = sum_sat;
    endcase
    if (target == '0) target = CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; expire <= 1'b0; tcnt <= '0;
    end else begin
      expire <= 1'b0;
      if (busy) begin
        if (tcnt == CNT_W'(1)) begin
          busy <= 1'b0; expire <= 1'b1;
        end else tcnt <= tcnt - 1'b1;
      end else if (req_valid) begin
        busy <= 1'b1; tcnt <= target;
      end
    end
  end
endmodule

// File: rtl/clk_ratio_timer_chk.sv
module clk_ratio_timer_chk #(
  parameter int RATIO_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cal_start,
  input logic [RATIO_W-1:0] ratio,
  input logic               cal_done,
  input logic               clk_missing,
  input logic               busy,
  input logic               expire
);
  // R2
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (!cal_done && !clk_missing));
  // R4
  ratio_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio) |-> $rose(cal_done));
  // R5
  missing_excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_missing) |-> !cal_done);
  // R9
  expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  // R9
  busy_ends_with_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> expire);
  // R9
  expire_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire) |-> $past(busy));
endmodule

bind clk_ratio_timer clk_ratio_timer_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .ratio(ratio),
  .cal_done(cal_done), .clk_missing(clk_missing), .busy(busy), .expire(expire)
);

// File: tb/clk_ratio_timer_tb.sv
module clk_ratio_timer_tb;
  localparam int RATIO_W = 20, UI_W = 16, ABS_W = 16, CNT_W = 16, TMO = 2000;

  logic clk = 0, rst_n = 0, tx_tgl = 0, cal_start = 0, req_valid = 0;
  logic [1:0] req_mode = 0;
  logic [UI_W-1:0] req_ui = 0;
  logic [ABS_W-1:0] req_abs = 0;
  logic [RATIO_W-1:0] ratio;
  logic cal_done, clk_missing, busy, expire;

  int checks = 0, errors = 0;
  longint cyc = 0;
  longint expq[$];
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_ratio_timer #(.RATIO_W(RATIO_W), .UI_W(UI_W), .ABS_W(ABS_W), .CNT_W(CNT_W),
                    .EDGES(256), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_tgl(tx_tgl), .cal_start(cal_start),
    .ratio(ratio), .cal_done(cal_done), .clk_missing(clk_missing),
    .req_valid(req_valid), .req_mode(req_mode), .req_ui(req_ui), .req_abs(req_abs),
    .busy(busy), .expire(expire));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint interval(int mode, longint n, longint a, longint r);
    longint maxv = (64'd1 << CNT_W) - 1;
    longint u = (n * r + 2047) / 2048;
    longint t;
    if (u > maxv) u = maxv;
    if (mode == 0) t = u;
    else if (mode == 1) t = a;
    else t = (u + a > maxv) ? maxv : u + a;
    return (t < 1) ? 1 : t;
  endfunction

  // monitor: pops expected expiry cycle on each pulse
  always @(negedge clk) begin
    if (rst_n && expire) begin
      if (expq.size() == 0) check("R10 unexpected expire", cyc, -1);
      else check("R9 expire cycle", cyc, expq.pop_front());
    end
  end

  task automatic calibrate(int p0, int p1, int ntog, longint old_ratio);
    @(negedge clk); cal_start = 1;
    @(negedge clk); cal_start = 0;
    check("R2 done cleared", cal_done, 0);
    check("R2 missing cleared", clk_missing, 0);
    for (int k = 0; k < ntog; k++) begin
      repeat ((k % 2) ? p1 : p0) @(negedge clk);
      tx_tgl = ~tx_tgl;
      if (k == 100) check("R4 ratio held mid-measurement", ratio, old_ratio);
    end
  endtask

  task automatic request(int mode, int n, int a, longint r);
    longint t = interval(mode, n, a, r);
    @(negedge clk);
    req_mode = 2'(mode); req_ui = UI_W'(n); req_abs = ABS_W'(a); req_valid = 1;
    expq.push_back(cyc + 1 + t);
    @(negedge clk); req_valid = 0;
    check("R9 busy after accept", busy, 1);
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ratio", ratio, 0);
    check("R1 done", cal_done, 0);
    check("R1 missing", clk_missing, 0);
    check("R1 expire", expire, 0);
    check("R1 busy", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    calibrate(4, 4, 257, 0);
    repeat (6) @(negedge clk);
    check("R2 done set", cal_done, 1);
    check("R3 ratio fixed period", ratio, 1024);

    calibrate(3, 4, 257, 1024);
    repeat (6) @(negedge clk);
    check("R2 done set", cal_done, 1);
    check("R3 ratio alternating period", ratio, 128*3 + 128*4);

    calibrate(4, 4, 3, 896);
    repeat (TMO + 20) @(negedge clk);
    check("R5 missing set", clk_missing, 1);
    check("R5 done low", cal_done, 0);
    check("R4 ratio kept after abort", ratio, 896);

    calibrate(5, 5, 257, 896);
    repeat (6) @(negedge clk);
    check("R2 restart completes", cal_done, 1);
    check("R3 ratio slow clock", ratio, 1280);

    request(0, 5, 0, 1280);   wait_idle();   // R6 rounding up
    request(0, 16, 0, 1280);  wait_idle();   // R6 exact
    request(1, 0, 37, 1280);  wait_idle();   // R7
    request(2, 16, 9, 1280);  wait_idle();   // R8
    request(3, 5, 20, 1280);  wait_idle();   // R8 mode 3
    request(1, 0, 0, 1280);   wait_idle();   // R9 zero -> one cycle
    request(0, 0, 0, 1280);   wait_idle();   // R6 zero
    request(1, 0, 40, 1280);                 // R10 request while busy
    repeat (5) @(negedge clk);
    req_mode = 2'd1; req_abs = 3; req_valid = 1;
    @(negedge clk); req_valid = 0;
    wait_idle();
    repeat (10) @(negedge clk);
    check("R10 no extra expiry", expq.size(), 0);
    check("R10 idle after ignored request", busy, 0);
    request(2, 65535, 40000, 1280); wait_idle();  // R8 saturation

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule